// File: doc/BRIEF.md
# Two-Vector-Testable Master-Slave D Flip-Flop

This block is a gate-level model of a master-slave D flip-flop in which every gate is a three-input, three-output controlled-swap cell. The cell passes its control input A straight through and either passes or crosses its other two inputs. Each output carries as many ones as the cell's inputs do. Each bit of the register is built from two latches. The master is transparent while the enable `en` is high. The slave is transparent while `en` is low, so no inverted clock is needed between them. In normal use the pair captures `d` on the falling edge of `en`.

Each latch uses two cells. The equation cell selects between the new data and the fed-back stored bit. The copy cell takes the stored bit on its control input and two mode bits on its data inputs. It duplicates the stored bit, so no net has fan-out, and it supplies the feedback. When both mode bits of a latch are equal, the feedback becomes that constant and the loop is broken. The flip-flop then behaves like combinational logic. Two vectors cover it for unidirectional stuck-at faults: all zeros finds stuck-at-1 faults, and all ones finds stuck-at-0 faults. Every cell output is brought out on an observation bus so that a tester can compare it with the applied constant.

The latches are level-sensitive in the `en` domain. Their state is kept in registers sampled on a free-running `clk`, which keeps the loop free of combinational cycles and lets it map onto ordinary fabric. `rst` is synchronous and active high.

Top module: `tvt_msdff`

## Requirements
- R1: Every cell maps inputs (A,B,C) to P=A, Q=A'B+AC, R=AB+A'C, so the output ones count equals the input ones count. The cells are:
  - Cell 0, master equation: A=`en`, B=master feedback, C=`d[i]`.
  - Cell 1, master copy: A=master state, B=`m_c1`, C=`m_c2`.
  - Cell 2, slave equation: A=`en`, B=slave feedback, C=master copy.
  - Cell 3, slave copy: A=slave state, B=`s_c1`, C=`s_c2`.

  The feedback of each latch is its copy cell's Q output. Bit i, cell k, pin j (P=0, Q=1, R=2) appears at `cell_obs[12*i+3*k+j]`.
- R2: A clock edge with `rst` high clears the master and slave state of every bit. After it, `q` is 0, and with mode bits 0,1 `qn` is all ones.
- R3: With `en` high, the master state (cell 1 P) after a `clk` edge equals the `d` sampled at that edge.
- R4: With `en` low and master mode bits 0,1, the master state keeps its value whatever `d` does.
- R5: With `en` low, the slave state `q` after an edge equals the master state before that edge. With `en` high and slave mode bits 0,1, `q` keeps its value.
- R6: With all mode bits at 0,1, `q` holds the `d` sampled at the last edge where `en` was high before `en` went low, and `qn` is the complement of `q`.
- R7: With a latch's mode bits both 0, its feedback is 0, so with `en` low the master loads 0 at the next edge.
- R8: With all four mode bits 0, `d` all zeros and `en` low, every bit of `cell_obs` is 0 from the second edge on.
- R9: With all four mode bits 1, `d` all ones and `en` high, every bit of `cell_obs` is 1 from the second edge on.
- R10: With a latch's mode bits both 1, its feedback is 1, so with `en` high the slave loads 1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the latch state registers |
| rst | input | 1 | Synchronous active-high reset of both latches |
| d | input | WIDTH | Data input |
| en | input | 1 | Latch enable: master transparent high, slave transparent low |
| m_c1 | input | 1 | Master copy-cell mode bit on input B |
| m_c2 | input | 1 | Master copy-cell mode bit on input C |
| s_c1 | input | 1 | Slave copy-cell mode bit on input B |
| s_c2 | input | 1 | Slave copy-cell mode bit on input C |
| q | output | WIDTH | Slave state |
| qn | output | WIDTH | Slave copy-cell R output, the complement of q in normal mode |
| cell_obs | output | 12*WIDTH | All cell outputs, packed as in R1 |

## Verification
A wrong master state shows on cell 1 P of `cell_obs` one edge after the faulty capture. It reaches `q` only at the next edge with `en` low, which may be many edges later in a long enable-high window. For that reason the master copy is compared every cycle and is not inferred from `q`. A broken feedback gate changes the equation cell's Q or R output in the same cycle, even while the stored bit still looks correct. After that the test vectors expose it within two edges as a bit of `cell_obs` that differs from the applied constant.

// File: rtl/tvt_pkg.sv
package tvt_pkg;

  localparam int CELL_PINS     = 3;
  localparam int CELLS_PER_BIT = 4;
  localparam int OBS_PER_BIT   = CELL_PINS * CELLS_PER_BIT;

  // input triple, A in bit 0
  typedef struct packed {
    logic c;
    logic b;
    logic a;
  } cell_in_t;

  // output triple, P in bit 0
  typedef struct packed {
    logic r;
    logic q;
    logic p;
  } cell_out_t;

  // controlled swap: A steers, B and C pass or cross
  function automatic cell_out_t cswap(input cell_in_t x);
    cell_out_t y;
    y.p = x.a;
    y.q = (~x.a & x.b) | (x.a & x.c);
    y.r = (x.a & x.b) | (~x.a & x.c);
    return y;
  endfunction

endpackage

// File: rtl/tvt_fredkin_cell.sv
module tvt_fredkin_cell
  import tvt_pkg::*;
(
  input  cell_in_t  cin,
  output cell_out_t cout
);

  assign cout = cswap(cin);

endmodule

// File: rtl/tvt_latch.sv
module tvt_latch
  import tvt_pkg::*;
#(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      din,
  input  logic      c1,
  input  logic      c2,
  output logic      state,
  output logic      fb,
  output cell_out_t eq_o,
  output cell_out_t cp_o
);

  cell_in_t eq_i;
  cell_in_t cp_i;
  logic     nxt;

  // equation cell: enable steers between fed-back bit and new data
  assign eq_i.a = en;
  assign eq_i.b = fb;
  assign eq_i.c = din;

  tvt_fredkin_cell u_eq (
    .cin  (eq_i),
    .cout (eq_o)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pos
      assign nxt = eq_o.q;   // en ? din : fb
    end else begin : g_neg
      assign nxt = eq_o.r;   // en ? fb : din
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) state <= 1'b0;
    else     state <= nxt;
  end

  // copy cell: stored bit on A, mode bits on B and C
  assign cp_i.a = state;
  assign cp_i.b = c1;
  assign cp_i.c = c2;

  tvt_fredkin_cell u_cp (
    .cin  (cp_i),
    .cout (cp_o)
  );

  assign fb = cp_o.q;

endmodule

// File: rtl/tvt_msdff.sv
module tvt_msdff
  import tvt_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int OBSW = WIDTH * OBS_PER_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  input  logic             en,
  input  logic             m_c1,
  input  logic             m_c2,
  input  logic             s_c1,
  input  logic             s_c2,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] qn,
  output logic [OBSW-1:0]  cell_obs
);

  logic [WIDTH-1:0] m_state;
  logic [WIDTH-1:0] m_fb;
  logic [WIDTH-1:0] s_state;
  logic [WIDTH-1:0] s_fb;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      cell_out_t m_eq, m_cp, s_eq, s_cp;

      tvt_latch #(.ACTIVE_HIGH(1'b1)) u_master (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .din   (d[i]),
        .c1    (m_c1),
        .c2    (m_c2),
        .state (m_state[i]),
        .fb    (m_fb[i]),
        .eq_o  (m_eq),
        .cp_o  (m_cp)
      );

      // slave takes its data from the master copy cell's pass-through
      tvt_latch #(.ACTIVE_HIGH(1'b0)) u_slave (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .din   (m_cp.p),
        .c1    (s_c1),
        .c2    (s_c2),
        .state (s_state[i]),
        .fb    (s_fb[i]),
        .eq_o  (s_eq),
        .cp_o  (s_cp)
      );

      assign q[i]  = s_cp.p;
      assign qn[i] = s_cp.r;
      assign cell_obs[i*OBS_PER_BIT +: OBS_PER_BIT] = {s_cp, s_eq, m_cp, m_eq};
    end
  endgenerate

endmodule

// File: rtl/tvt_msdff_chk.sv
module tvt_msdff_chk #(
  parameter int WIDTH = 4,
  localparam int OBSW = WIDTH * 12
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] d,
  input logic             en,
  input logic             m_c1,
  input logic             m_c2,
  input logic             s_c1,
  input logic             s_c2,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] qn,
  input logic [OBSW-1:0]  cell_obs,
  input logic [WIDTH-1:0] m_state,
  input logic [WIDTH-1:0] m_fb,
  input logic [WIDTH-1:0] s_state,
  input logic [WIDTH-1:0] s_fb
);

  logic m_norm, s_norm;
  assign m_norm = !m_c1 && m_c2;
  assign s_norm = !s_c1 && s_c2;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q == '0 && m_state == '0)); // R2
  AST_MASTER_FOLLOW: assert property (@(posedge clk) disable iff (rst) (en) |=> (m_state == $past(d))); // R3
  AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (rst) (!en && m_norm) |=> $stable(m_state)); // R4
  AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (rst) (!en) |=> (s_state == $past(m_state))); // R5
  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (rst) (en && s_norm) |=> $stable(q)); // R5
  AST_QN_COMPL: assert property (@(posedge clk) disable iff (rst) s_norm |-> (qn == ~q)); // R6
  AST_FB_ZERO: assert property (@(posedge clk) disable iff (rst) (!m_c1 && !m_c2 && !s_c1 && !s_c2) |-> (m_fb == '0 && s_fb == '0)); // R7
  AST_FB_ONE: assert property (@(posedge clk) disable iff (rst) (m_c1 && m_c2 && s_c1 && s_c2) |-> (m_fb == '1 && s_fb == '1)); // R10

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cons
      AST_ONES_CELL0: assert property (@(posedge clk) disable iff (rst) $countones(cell_obs[i*12 +: 3]) == $countones({en, m_fb[i], d[i]})); // R1
      AST_ONES_CELL1: assert property (@(posedge clk) disable iff (rst) $countones(cell_obs[i*12+3 +: 3]) == $countones({m_state[i], m_c1, m_c2})); // R1
      AST_ONES_CELL2: assert property (@(posedge clk) disable iff (rst) $countones(cell_obs[i*12+6 +: 3]) == $countones({en, s_fb[i], m_state[i]})); // R1
      AST_ONES_CELL3: assert property (@(posedge clk) disable iff (rst) $countones(cell_obs[i*12+9 +: 3]) == $countones({s_state[i], s_c1, s_c2})); // R1
    end
  endgenerate

endmodule

bind tvt_msdff tvt_msdff_chk #(.WIDTH(WIDTH)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .d        (d),
  .en       (en),
  .m_c1     (m_c1),
  .m_c2     (m_c2),
  .s_c1     (s_c1),
  .s_c2     (s_c2),
  .q        (q),
  .qn       (qn),
  .cell_obs (cell_obs),
  .m_state  (m_state),
  .m_fb     (m_fb),
  .s_state  (s_state),
  .s_fb     (s_fb)
);

// File: tb/test_tvt_msdff.sv
`timescale 1ns/1ps
module test_tvt_msdff;

  localparam int W    = 4;
  localparam int OBSW = W * 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [W-1:0]    d = '0;
  logic            en = 1'b0;
  logic            m_c1 = 1'b0, m_c2 = 1'b1, s_c1 = 1'b0, s_c2 = 1'b1;
  logic [W-1:0]    q, qn;
  logic [OBSW-1:0] cell_obs;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] ref_m, ref_s;

  always #4 clk = ~clk;

  tvt_msdff #(.WIDTH(W)) i_tvt_msdff (
    .clk(clk), .rst(rst), .d(d), .en(en),
    .m_c1(m_c1), .m_c2(m_c2), .s_c1(s_c1), .s_c2(s_c2),
    .q(q), .qn(qn), .cell_obs(cell_obs)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // master state as seen on cell 1 P of each bit
  function automatic logic [W-1:0] obs_master(input logic [OBSW-1:0] o);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = o[i*12 + 3];
    return m;
  endfunction

  // expected {R,Q,P} of a controlled-swap cell
  function automatic logic [2:0] cell_exp(input logic a, input logic b, input logic c);
    return {a ? b : c, a ? c : b, a};
  endfunction

  task automatic set_mode(input logic mc1, input logic mc2, input logic sc1, input logic sc2);
    m_c1 = mc1; m_c2 = mc2; s_c1 = sc1; s_c2 = sc2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; d = '0;
    set_mode(1'b0, 1'b1, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(q == '0, "R2 q", q, '0);
    chk(qn == '1, "R2 qn", qn, '1);
    chk(obs_master(cell_obs) == '0, "R2 master", obs_master(cell_obs), '0);
    rst = 1'b0;
    ref_m = '0; ref_s = '0;
  endtask

  // one normal-mode cycle: check, then drive and advance the reference
  task automatic normal_step(input logic nen, input logic [W-1:0] nd, input string mtag);
    @(negedge clk);
    chk(q == ref_s, "R6 q", q, ref_s);
    chk(qn == ~ref_s, "R6 qn", qn, ~ref_s);
    chk(obs_master(cell_obs) == ref_m, mtag, obs_master(cell_obs), ref_m);
    for (int i = 0; i < W; i++) begin
      logic [2:0] e0;
      e0 = cell_exp(en, cell_obs[i*12 + 4], d[i]);
      chk(cell_obs[i*12 +: 3] == e0, "R1 cell0", cell_obs[i*12 +: 3], e0);
    end
    en = nen; d = nd;
    if (!nen) ref_s = ref_m;   // slave copies the old master value
    if (nen)  ref_m = nd;
  endtask

  initial begin
    void'($urandom(32'h1d5_0042));
    do_reset();

    // constrained random normal mode
    for (int k = 0; k < 600; k++) begin
      logic ne;
      ne = ($urandom_range(0, 2) != 0) ? en : ~en;
      normal_step(ne, W'($urandom), en ? "R3 master" : "R4 master");
    end

    // directed: long enable-high window, slave must hold (R5)
    normal_step(1'b1, 4'hA, "R3 master");
    normal_step(1'b1, 4'h5, "R3 master");
    normal_step(1'b1, 4'hC, "R3 master");
    normal_step(1'b0, 4'h3, "R3 master");
    @(negedge clk);
    chk(q == 4'hC, "R5 slave after fall", q, 4'hC);
    // directed: enable low, master must ignore d (R4)
    en = 1'b0; d = 4'hF;
    @(negedge clk);
    d = 4'h0;
    @(negedge clk);
    chk(obs_master(cell_obs) == 4'hC, "R4 master hold", obs_master(cell_obs), 4'hC);
    chk(q == 4'hC, "R5 slave", q, 4'hC);

    // R7: load master with ones, then force feedback to 0
    en = 1'b1; d = '1;
    @(negedge clk);
    chk(obs_master(cell_obs) == '1, "R3 preload", obs_master(cell_obs), '1);
    set_mode(1'b0, 1'b0, 1'b0, 1'b0); en = 1'b0;
    @(negedge clk);
    chk(obs_master(cell_obs) == '0, "R7 master forced", obs_master(cell_obs), '0);

    // R8: all-zeros vector
    d = '0; en = 1'b0;
    repeat (2) @(negedge clk);
    chk(cell_obs == '0, "R8 all zeros", cell_obs, '0);
    chk(q == '0, "R8 q", q, '0);

    // R10: slave was 0; ones mode with enable high loads 1 into the slave
    set_mode(1'b1, 1'b1, 1'b1, 1'b1); en = 1'b1; d = '1;
    @(negedge clk);
    chk(q == '1, "R10 slave forced", q, '1);

    // R9: all-ones vector
    @(negedge clk);
    chk(cell_obs == '1, "R9 all ones", cell_obs, '1);

    // back to normal after a reset
    do_reset();
    normal_step(1'b1, 4'h6, "R3 master");
    normal_step(1'b0, 4'h9, "R3 master");
    normal_step(1'b0, 4'h9, "R4 master");
    @(negedge clk);
    chk(q == 4'h6, "R6 edge capture", q, 4'h6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule